// File: doc/BRIEF.md
# Dual-Link DVI Pixel Lane Mapper

This block sits between the internal pixel bus of a video design and two pairs of single-link DVI devices. One pair receives and one pair transmits. Each pair has a primary (master) device and a secondary (slave) device.

On the receive side the block returns two pixels per clock: an even pixel and an odd pixel.
- In single-link operation, both pixels come from the master receiver's double-width bus.
- In dual-link operation, the even pixel comes from the master and the odd pixel comes from the slave. The slave presents its bus with the bit order reversed, and the block puts it back in normal order.

On the transmit side each internal pixel goes out in one of two ways:
- In single-link operation it goes whole to the master transmitter.
- In dual-link operation its low half goes to the master and its high half goes to the slave.

A single request input selects the link mode. Each direction adopts a new mode only while its own data-enable is low, so a mode change can never split an active line. Every output is registered once on the pixel clock, and the sync and enable flags travel alongside the data with the same delay.

Top module: `dvi_lane_mapper`

## Requirements
- R1: While reset is asserted, every output is 0. After reset, both directions start in single-link mode: if DE is high from the first cycle, single-link mapping applies even when dual-link is requested.
- R2: Every output changes only on a rising clock edge. An output reflects the inputs sampled at the previous edge, which is one cycle of latency.
- R3: In receive single-link mode, the even pixel equals master bits 23:0 and the odd pixel equals master bits 47:24.
- R4: In receive dual-link mode, the even pixel equals master bits 23:0. The odd pixel is the slave bus reversed: odd bit k equals slave bit 23-k. Master bits 47:24 are ignored.
- R5: In receive single-link mode, the slave bus has no effect on any output.
- R6: The received HSYNC, VSYNC and DE come from the master receiver. They appear on the pixel-side sync outputs with the same one-cycle latency as the data.
- R7: In transmit single-link mode, the master data equals the full 24-bit pixel and the 12-bit slave data is held at 0.
- R8: In transmit dual-link mode, master data bits 11:0 equal pixel bits 11:0 and master bits 23:12 are 0. The slave data equals pixel bits 23:12.
- R9: The transmit HSYNC, VSYNC and DE are forwarded to the device-side outputs with one cycle of latency.
- R10: The receive path adopts the mode request (1 = dual-link, 0 = single-link) only in cycles where the received DE is low. In such a cycle, the new mode already applies to that cycle's data. While DE is high, the previously adopted mode is kept.
- R11: The transmit path adopts the mode request in the same way, gated by the transmit DE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_link_i | input | 1 | Mode request, 1 = dual-link |
| rx_m_data_i | input | 48 | Master receiver data bus |
| rx_s_data_i | input | 24 | Slave receiver data bus (bit-reversed) |
| rx_hsync_i | input | 1 | Master receiver HSYNC |
| rx_vsync_i | input | 1 | Master receiver VSYNC |
| rx_de_i | input | 1 | Master receiver data enable |
| pix_even_o | output | 24 | Rebuilt even pixel |
| pix_odd_o | output | 24 | Rebuilt odd pixel |
| pix_hsync_o | output | 1 | Registered receive HSYNC |
| pix_vsync_o | output | 1 | Registered receive VSYNC |
| pix_de_o | output | 1 | Registered receive DE |
| tx_pix_i | input | 24 | Pixel to transmit |
| tx_hsync_i | input | 1 | Transmit HSYNC |
| tx_vsync_i | input | 1 | Transmit VSYNC |
| tx_de_i | input | 1 | Transmit data enable |
| tx_m_data_o | output | 24 | Master transmitter data |
| tx_s_data_o | output | 12 | Slave transmitter data |
| tx_hsync_o | output | 1 | Registered transmit HSYNC |
| tx_vsync_o | output | 1 | Registered transmit VSYNC |
| tx_de_o | output | 1 | Registered transmit DE |

## Verification
The only internal state is the mode held by each direction.

A wrong held mode on the receive side shows up within one cycle of the next active pixel:
- the odd pixel follows the wrong source, master high half instead of the reversed slave bus or the other way round.

A wrong held mode on the transmit side shows up within one cycle of the next active pixel:
- either the slave lane carries data in single-link mode,
- or the master's upper half is cleared in single-link mode.

The tests move the mode request while DE is high and check that the mapping does not change until DE has dropped. A fault in the reversal or the lane split shows up on the very first pixel after the mode is adopted.

// File: rtl/dvi_lane_pkg.sv
package dvi_lane_pkg;
   typedef enum logic {
      LINK_SINGLE = 1'b0,
      LINK_DUAL   = 1'b1
   } link_mode_e;

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
   } vid_ctl_t;
endpackage

// File: rtl/dvi_mode_gate.sv
module dvi_mode_gate
   import dvi_lane_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       de_i,
   input  link_mode_e req_i,
   output link_mode_e eff_o,
   output link_mode_e held_o
);
   link_mode_e held_q;

   // The request passes straight through while blanking;
   // during active video the latched mode is used.
   always_comb eff_o = de_i ? held_q : req_i;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= LINK_SINGLE;
      else        held_q <= eff_o;
   end

   assign held_o = held_q;
endmodule

// File: rtl/dvi_rx_merge.sv
module dvi_rx_merge
   import dvi_lane_pkg::*;
#(
   parameter int PIX_W          = 24,
   parameter bit SLAVE_REVERSED = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  link_mode_e         mode_i,
   input  logic [2*PIX_W-1:0] m_bus_i,
   input  logic [PIX_W-1:0]   s_bus_i,
   input  vid_ctl_t           ctl_i,
   output logic [PIX_W-1:0]   even_o,
   output logic [PIX_W-1:0]   odd_o,
   output vid_ctl_t           ctl_o
);
   logic [PIX_W-1:0] s_fix;
   logic [PIX_W-1:0] odd_nxt;

   generate
      if (SLAVE_REVERSED) begin : g_rev
         for (genvar i = 0; i < PIX_W; i++) begin : g_bit
            assign s_fix[i] = s_bus_i[PIX_W-1-i];
         end
      end else begin : g_straight
         assign s_fix = s_bus_i;
      end
   endgenerate

   always_comb odd_nxt = (mode_i == LINK_DUAL) ? s_fix : m_bus_i[2*PIX_W-1:PIX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         even_o <= '0;
         odd_o  <= '0;
         ctl_o  <= '0;
      end else begin
         even_o <= m_bus_i[PIX_W-1:0];
         odd_o  <= odd_nxt;
         ctl_o  <= ctl_i;
      end
   end
endmodule

// File: rtl/dvi_tx_split.sv
module dvi_tx_split
   import dvi_lane_pkg::*;
#(
   parameter int PIX_W  = 24,
   localparam int HALF_W = PIX_W / 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  link_mode_e        mode_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  vid_ctl_t          ctl_i,
   output logic [PIX_W-1:0]  m_o,
   output logic [HALF_W-1:0] s_o,
   output vid_ctl_t          ctl_o
);
   logic [PIX_W-1:0]  m_nxt;
   logic [HALF_W-1:0] s_nxt;

   always_comb begin
      if (mode_i == LINK_DUAL) begin
         m_nxt = {{(PIX_W-HALF_W){1'b0}}, pix_i[HALF_W-1:0]};
         s_nxt = pix_i[PIX_W-1:HALF_W];
      end else begin
         m_nxt = pix_i;
         s_nxt = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_o   <= '0;
         s_o   <= '0;
         ctl_o <= '0;
      end else begin
         m_o   <= m_nxt;
         s_o   <= s_nxt;
         ctl_o <= ctl_i;
      end
   end
endmodule

// File: rtl/dvi_lane_mapper.sv
module dvi_lane_mapper
   import dvi_lane_pkg::*;
#(
   parameter int PIX_W          = 24,
   parameter bit SLAVE_REVERSED = 1'b1,
   localparam int HALF_W = PIX_W / 2,
   localparam int BUS_W  = 2 * PIX_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dual_link_i,
   input  logic [BUS_W-1:0]  rx_m_data_i,
   input  logic [PIX_W-1:0]  rx_s_data_i,
   input  logic              rx_hsync_i,
   input  logic              rx_vsync_i,
   input  logic              rx_de_i,
   output logic [PIX_W-1:0]  pix_even_o,
   output logic [PIX_W-1:0]  pix_odd_o,
   output logic              pix_hsync_o,
   output logic              pix_vsync_o,
   output logic              pix_de_o,
   input  logic [PIX_W-1:0]  tx_pix_i,
   input  logic              tx_hsync_i,
   input  logic              tx_vsync_i,
   input  logic              tx_de_i,
   output logic [PIX_W-1:0]  tx_m_data_o,
   output logic [HALF_W-1:0] tx_s_data_o,
   output logic              tx_hsync_o,
   output logic              tx_vsync_o,
   output logic              tx_de_o
);
   generate
      if ((PIX_W % 2) != 0 || PIX_W < 2) begin : g_bad_width
         $error("dvi_lane_mapper: PIX_W must be even and at least 2");
      end
   endgenerate

   link_mode_e req;
   link_mode_e rx_mode_eff, rx_mode_held;
   link_mode_e tx_mode_eff, tx_mode_held;
   vid_ctl_t   rx_ctl_in, rx_ctl_out, tx_ctl_in, tx_ctl_out;

   assign req       = link_mode_e'(dual_link_i);
   assign rx_ctl_in = '{hs: rx_hsync_i, vs: rx_vsync_i, de: rx_de_i};
   assign tx_ctl_in = '{hs: tx_hsync_i, vs: tx_vsync_i, de: tx_de_i};

   dvi_mode_gate u_rx_gate (
      .clk(clk), .rst_n(rst_n), .de_i(rx_de_i), .req_i(req),
      .eff_o(rx_mode_eff), .held_o(rx_mode_held)
   );

   dvi_mode_gate u_tx_gate (
      .clk(clk), .rst_n(rst_n), .de_i(tx_de_i), .req_i(req),
      .eff_o(tx_mode_eff), .held_o(tx_mode_held)
   );

   dvi_rx_merge #(.PIX_W(PIX_W), .SLAVE_REVERSED(SLAVE_REVERSED)) u_rx (
      .clk(clk), .rst_n(rst_n), .mode_i(rx_mode_eff),
      .m_bus_i(rx_m_data_i), .s_bus_i(rx_s_data_i), .ctl_i(rx_ctl_in),
      .even_o(pix_even_o), .odd_o(pix_odd_o), .ctl_o(rx_ctl_out)
   );

   dvi_tx_split #(.PIX_W(PIX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .mode_i(tx_mode_eff),
      .pix_i(tx_pix_i), .ctl_i(tx_ctl_in),
      .m_o(tx_m_data_o), .s_o(tx_s_data_o), .ctl_o(tx_ctl_out)
   );

   assign pix_hsync_o = rx_ctl_out.hs;
   assign pix_vsync_o = rx_ctl_out.vs;
   assign pix_de_o    = rx_ctl_out.de;
   assign tx_hsync_o  = tx_ctl_out.hs;
   assign tx_vsync_o  = tx_ctl_out.vs;
   assign tx_de_o     = tx_ctl_out.de;
endmodule

// File: rtl/dvi_lane_mapper_chk.sv
module dvi_lane_mapper_chk #(
   parameter int PIX_W  = 24,
   localparam int HALF_W = PIX_W / 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rx_de_i,
   input logic              rx_hsync_i,
   input logic              pix_de_o,
   input logic              pix_hsync_o,
   input logic              tx_de_i,
   input logic              tx_de_o,
   input logic [PIX_W-1:0]  tx_pix_i,
   input logic [PIX_W-1:0]  tx_m_data_o,
   input logic [HALF_W-1:0] tx_s_data_o,
   input logic              rx_mode_held,
   input logic              tx_mode_held
);
   logic primed;

   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R6
   rx_sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (pix_de_o == $past(rx_de_i)) && (pix_hsync_o == $past(rx_hsync_i)));

   // R9
   tx_sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> tx_de_o == $past(tx_de_i));

   // R8
   tx_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> tx_m_data_o[HALF_W-1:0] == $past(tx_pix_i[HALF_W-1:0]));

   // R7
   tx_lane_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_s_data_o != '0) |-> (tx_m_data_o[PIX_W-1:HALF_W] == '0));

   // R10
   rx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(rx_de_i)) |-> $stable(rx_mode_held));

   // R11
   tx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(tx_de_i)) |-> $stable(tx_mode_held));
endmodule

bind dvi_lane_mapper dvi_lane_mapper_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rx_de_i(rx_de_i), .rx_hsync_i(rx_hsync_i),
   .pix_de_o(pix_de_o), .pix_hsync_o(pix_hsync_o),
   .tx_de_i(tx_de_i), .tx_de_o(tx_de_o), .tx_pix_i(tx_pix_i),
   .tx_m_data_o(tx_m_data_o), .tx_s_data_o(tx_s_data_o),
   .rx_mode_held(rx_mode_held), .tx_mode_held(tx_mode_held)
);

// File: tb/tb_dvi_lane_mapper.sv
module tb_dvi_lane_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dual_link_i = 1'b0;
   logic [47:0] rx_m_data_i = '0;
   logic [23:0] rx_s_data_i = '0;
   logic        rx_hsync_i = 1'b0, rx_vsync_i = 1'b0, rx_de_i = 1'b0;
   logic [23:0] pix_even_o, pix_odd_o;
   logic        pix_hsync_o, pix_vsync_o, pix_de_o;
   logic [23:0] tx_pix_i = '0;
   logic        tx_hsync_i = 1'b0, tx_vsync_i = 1'b0, tx_de_i = 1'b0;
   logic [23:0] tx_m_data_o;
   logic [11:0] tx_s_data_o;
   logic        tx_hsync_o, tx_vsync_o, tx_de_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dvi_lane_mapper dut (.*);

   task automatic chk(input string req, input string what,
                      input logic [47:0] got, input logic [47:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   function automatic logic [23:0] rev24(input logic [23:0] v);
      logic [23:0] r;
      for (int k = 0; k < 24; k++) r[k] = v[23-k];
      return r;
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drive_rx(input logic mode, input logic de,
                           input logic [47:0] m, input logic [23:0] s,
                           input logic hs, input logic vs);
      @(negedge clk);
      dual_link_i = mode; rx_de_i = de; rx_m_data_i = m; rx_s_data_i = s;
      rx_hsync_i = hs; rx_vsync_i = vs;
   endtask

   task automatic drive_tx(input logic mode, input logic de,
                           input logic [23:0] p, input logic hs, input logic vs);
      @(negedge clk);
      dual_link_i = mode; tx_de_i = de; tx_pix_i = p;
      tx_hsync_i = hs; tx_vsync_i = vs;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive_rx(1'b1, 1'b1, 48'hFFFF_FFFF_FFFF, 24'hFFFFFF, 1'b1, 1'b1);
      drive_tx(1'b1, 1'b1, 24'hFFFFFF, 1'b1, 1'b1);
      step(); step();
      chk("R1", "rx even in reset", {24'h0, pix_even_o}, 48'h0);
      chk("R1", "rx odd in reset",  {24'h0, pix_odd_o}, 48'h0);
      chk("R1", "rx ctl in reset",  {45'h0, pix_hsync_o, pix_vsync_o, pix_de_o}, 48'h0);
      chk("R1", "tx in reset", {tx_m_data_o, tx_s_data_o, 9'h0, tx_hsync_o, tx_vsync_o, tx_de_o}, 48'h0);
      // Release reset with DE high and dual requested: the held mode must be single.
      @(negedge clk);
      rst_n = 1'b1;
      rx_m_data_i = 48'hABCDEF_123456; rx_s_data_i = 24'h00000F;
      tx_pix_i = 24'h5A5A5A;
      step();
      chk("R1", "rx odd single after reset", {24'h0, pix_odd_o}, 48'hABCDEF);
      chk("R1", "tx master single after reset", {24'h0, tx_m_data_o}, 48'h5A5A5A);
      chk("R1", "tx slave idle after reset", {36'h0, tx_s_data_o}, 48'h0);
   endtask

   task automatic t_rx_single();
      drive_rx(1'b0, 1'b0, 48'h111111_222222, 24'h0, 1'b0, 1'b0);
      step();
      drive_rx(1'b0, 1'b1, 48'hC0FFEE_BADA55, 24'h777777, 1'b1, 1'b0);
      step();
      chk("R3", "single even", {24'h0, pix_even_o}, 48'hBADA55);
      chk("R3", "single odd",  {24'h0, pix_odd_o}, 48'hC0FFEE);
      chk("R6", "sync forward", {45'h0, pix_hsync_o, pix_vsync_o, pix_de_o}, 48'h5);
      // R2: new inputs must not show before the next edge
      drive_rx(1'b0, 1'b1, 48'h0F0F0F_F0F0F0, 24'h123456, 1'b0, 1'b1);
      #1;
      chk("R2", "even held before edge", {24'h0, pix_even_o}, 48'hBADA55);
      chk("R2", "de held before edge", {47'h0, pix_de_o}, 48'h1);
      step();
      chk("R5", "slave ignored odd", {24'h0, pix_odd_o}, 48'h0F0F0F);
      chk("R5", "slave ignored even", {24'h0, pix_even_o}, 48'hF0F0F0);
      chk("R6", "vsync forward", {45'h0, pix_hsync_o, pix_vsync_o, pix_de_o}, 48'h3);
   endtask

   task automatic t_rx_dual();
      drive_rx(1'b1, 1'b0, 48'hEEEEEE_000001, 24'h800001, 1'b0, 1'b0);
      step();
      chk("R10", "dual adopted in blanking", {24'h0, pix_odd_o}, {24'h0, rev24(24'h800001)});
      drive_rx(1'b1, 1'b1, 48'hFFFFFF_ABCDEF, 24'hF00003, 1'b0, 1'b0);
      step();
      chk("R4", "dual even", {24'h0, pix_even_o}, 48'hABCDEF);
      chk("R4", "dual odd reversed", {24'h0, pix_odd_o}, {24'h0, rev24(24'hF00003)});
   endtask

   task automatic t_rx_hold();
      // held mode is dual now; request single while DE high
      drive_rx(1'b0, 1'b1, 48'h123123_456456, 24'h000100, 1'b0, 1'b0);
      step();
      chk("R10", "mode kept during DE", {24'h0, pix_odd_o}, {24'h0, rev24(24'h000100)});
      drive_rx(1'b0, 1'b0, 48'h123123_456456, 24'h000100, 1'b0, 1'b0);
      step();
      chk("R10", "single after DE low", {24'h0, pix_odd_o}, 48'h123123);
      drive_rx(1'b1, 1'b1, 48'h999999_888888, 24'h000001, 1'b0, 1'b0);
      step();
      chk("R10", "dual request ignored during DE", {24'h0, pix_odd_o}, 48'h999999);
      drive_rx(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_tx_single();
      drive_tx(1'b0, 1'b0, 24'h0, 1'b0, 1'b0);
      step();
      drive_tx(1'b0, 1'b1, 24'hFEDCBA, 1'b1, 1'b0);
      step();
      chk("R7", "single master", {24'h0, tx_m_data_o}, 48'hFEDCBA);
      chk("R7", "single slave idle", {36'h0, tx_s_data_o}, 48'h0);
      chk("R9", "tx sync", {45'h0, tx_hsync_o, tx_vsync_o, tx_de_o}, 48'h5);
   endtask

   task automatic t_tx_dual();
      drive_tx(1'b1, 1'b0, 24'h123456, 1'b0, 1'b1);
      step();
      chk("R11", "tx dual adopted in blanking", {36'h0, tx_s_data_o}, 48'h123);
      drive_tx(1'b1, 1'b1, 24'hABCDEF, 1'b0, 1'b0);
      step();
      chk("R8", "dual master low half", {24'h0, tx_m_data_o}, 48'h000DEF);
      chk("R8", "dual slave high half", {36'h0, tx_s_data_o}, 48'hABC);
      chk("R9", "tx de", {45'h0, tx_hsync_o, tx_vsync_o, tx_de_o}, 48'h1);
   endtask

   task automatic t_tx_hold();
      drive_tx(1'b0, 1'b1, 24'h765432, 1'b0, 1'b0);
      step();
      chk("R11", "tx mode kept during DE", {24'h0, tx_m_data_o}, 48'h000432);
      drive_tx(1'b0, 1'b0, 24'h765432, 1'b0, 1'b0);
      step();
      chk("R11", "tx single after DE low", {24'h0, tx_m_data_o}, 48'h765432);
      drive_tx(1'b1, 1'b1, 24'h111222, 1'b0, 1'b0);
      step();
      chk("R11", "tx dual request ignored during DE", {36'h0, tx_s_data_o}, 48'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_rx_single();
      t_rx_dual();
      t_rx_hold();
      t_tx_single();
      t_tx_dual();
      t_tx_hold();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule